// File: doc/BRIEF.md
# Multi-Chip SPI DAC Update Sequencer

The sequencer drives a group of dual-output DAC chips that share one serial clock and one data line. Each chip has its own active-low select, and all chips share one active-low load strobe. On a start pulse it captures a requested channel count and a latch flag. It then sends one 16-bit command frame per channel, in ascending channel order. Even channels go to output A of chip `i/2` and odd channels go to output B of the same chip. Each frame combines a 4-bit command nibble with the low 12 bits of the channel's sample.

When a latched update is requested, the sequencer waits after the last frame for a minimum setup time. It then pulses the shared load strobe low for a minimum width, so every output changes at the same moment. Both minimums are given in nanoseconds and converted to clock cycles, rounded up. The sample bus is read while frames are built, so it must stay stable from start until done.

Top module: `dac_seq_top`

## Requirements
- R1: After reset and while idle, every chip select and the load strobe are high, the serial clock is low and busy is low.
- R2: Each frame is 16 serial clock pulses, MSB first, in SPI mode 0: the clock idles low and the data line changes only while the clock is low.
- R3: The frame word is {sel, 0, 1, 1, value[11:0]}. Bit 15 is 0 for output A and 1 for output B, which gives nibble 0x3 for A and 0xB for B.
- R4: For each frame, exactly the addressed chip's select is low, for that frame only. All selects return high between frames.
- R5: The requested count is clamped to the range 1 to 2*N_CHIPS. A request of 0 sends one frame.
- R6: Channel i (0-based) goes to chip i/2. Even i uses output A and odd i uses output B. Channels are sent in ascending order, so an odd count ends on an A frame.
- R7: With the latch flag set at start, the load strobe stays high during all frames. It falls no sooner than SETUP_CYC cycles after the last select rises, stays low exactly PULSE_CYC cycles, then returns high.
- R8: With the latch flag clear at start, the load strobe never leaves high.
- R9: Busy is high from the cycle after start until done. Done is a single-cycle pulse. A start, or a change of the latch flag, while busy has no effect.
- R10: SETUP_CYC = ceil(SETUP_NS/CLK_NS) and PULSE_CYC = ceil(PULSE_NS/CLK_NS). With the defaults (10 ns clock, 40 ns, 100 ns) these are 4 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a batch (taken only while idle) |
| latch_req | input | 1 | Pulse the load strobe after the frames |
| chan_count | input | CNT_W | Requested number of channels |
| samples | input | 2*N_CHIPS*12 | Channel k sample in bits [12k+11:12k] |
| busy | output | 1 | Batch in progress |
| done | output | 1 | One-cycle end-of-batch pulse |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data, MSB first |
| cs_n | output | N_CHIPS | Per-chip active-low select |
| ldac_n | output | 1 | Shared active-low load strobe |

## Verification
The assertions check the cycle-level rules on every cycle:
- at most one select is low;
- the load strobe is never low while a select is low;
- nothing is active while idle;
- the data line is stable while the serial clock is high;
- each frame ends with the serial clock low;
- a strobe pulse, once started, lasts more than one cycle.

Only the bench scenarios can show the content of each frame (word value, chip and order), the clamping of counts, the setup gap and the exact pulse width, and that a start issued while busy is ignored.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
  localparam int DATA_W  = 12;
  localparam int CMD_W   = 4;
  localparam int FRAME_W = DATA_W + CMD_W;

  // Round a nanosecond figure up to whole clock cycles (at least one).
  function automatic int ns_to_cycles(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  // Keep a requested channel count inside 1..max_ch.
  function automatic int clamp_count(input int req, input int max_ch);
    if (req < 1) return 1;
    if (req > max_ch) return max_ch;
    return req;
  endfunction

  // Command word: output select, unbuffered, unity gain, active.
  function automatic logic [FRAME_W-1:0] build_word(input logic sel_b,
                                                     input logic [DATA_W-1:0] val);
    return {sel_b, 1'b0, 1'b1, 1'b1, val};
  endfunction
endpackage

// File: rtl/dac_spi_frame.sv
module dac_spi_frame #(
  parameter int FRAME_W  = 16,
  parameter int HALF_DIV = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [FRAME_W-1:0] word,
  output logic               active,
  output logic               fin,
  output logic               sclk,
  output logic               mosi
);
  localparam int DIV_W = $clog2(HALF_DIV) + 1;
  localparam int BIT_W = $clog2(FRAME_W) + 1;

  logic [FRAME_W-1:0] shreg;
  logic [DIV_W-1:0]   div_q;
  logic [BIT_W-1:0]   bit_q;
  logic               half_tick;
  logic               last_bit;

  assign half_tick = (div_q == DIV_W'(HALF_DIV - 1));
  assign last_bit  = (bit_q == BIT_W'(FRAME_W - 1));
  assign mosi      = shreg[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      fin    <= 1'b0;
      sclk   <= 1'b0;
      shreg  <= '0;
      div_q  <= '0;
      bit_q  <= '0;
    end else begin
      fin <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1;
          shreg  <= word;
          sclk   <= 1'b0;
          div_q  <= '0;
          bit_q  <= '0;
        end
      end else if (!half_tick) begin
        div_q <= div_q + 1'b1;
      end else begin
        div_q <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
        end else begin
          sclk <= 1'b0;
          if (last_bit) begin
            active <= 1'b0;
            fin    <= 1'b1;
          end else begin
            shreg <= {shreg[FRAME_W-2:0], 1'b0};
            bit_q <= bit_q + 1'b1;
          end
        end
      end
    end
  end

  // R2
  mosi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R2
  frame_end_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> !sclk);
endmodule

// File: rtl/dac_load_strobe.sv
module dac_load_strobe #(
  parameter int SETUP_CYC = 4,
  parameter int PULSE_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic ldac_n,
  output logic fin
);
  localparam int MAXC  = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1) + 1;

  typedef enum logic [1:0] {LS_IDLE, LS_SETUP, LS_LOW} ls_t;
  ls_t              st;
  logic [CNT_W-1:0] cnt;

  assign ldac_n = (st != LS_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= LS_IDLE;
      cnt <= '0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        LS_IDLE: if (go) begin
          st  <= LS_SETUP;
          cnt <= '0;
        end
        LS_SETUP: if (cnt == CNT_W'(SETUP_CYC - 1)) begin
          st  <= LS_LOW;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        default: if (cnt == CNT_W'(PULSE_CYC - 1)) begin
          st  <= LS_IDLE;
          fin <= 1'b1;
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end

  // R7
  strobe_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ldac_n) |=> (PULSE_CYC < 2) || !ldac_n);
endmodule

// File: rtl/dac_seq_top.sv
module dac_seq_top
  import dac_seq_pkg::*;
#(
  parameter int N_CHIPS  = 2,
  parameter int CLK_NS   = 10,
  parameter int SETUP_NS = 40,
  parameter int PULSE_NS = 100,
  parameter int HALF_DIV = 2,
  parameter int CNT_W    = $clog2(2 * N_CHIPS + 1) + 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic                           latch_req,
  input  logic [CNT_W-1:0]               chan_count,
  input  logic [2*N_CHIPS*DATA_W-1:0]    samples,
  output logic                           busy,
  output logic                           done,
  output logic                           sclk,
  output logic                           mosi,
  output logic [N_CHIPS-1:0]             cs_n,
  output logic                           ldac_n
);
  localparam int N_CH      = 2 * N_CHIPS;
  localparam int SETUP_CYC = ns_to_cycles(SETUP_NS, CLK_NS);
  localparam int PULSE_CYC = ns_to_cycles(PULSE_NS, CLK_NS);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_WAIT, S_LATCH, S_DONE} st_t;
  st_t              st;
  logic [CNT_W-1:0] cnt_q, idx_q;
  logic             lat_q;

  logic               tx_go, tx_active, tx_fin;
  logic               ls_go, ls_fin;
  logic               last_frame;
  logic [CNT_W-1:0]   chip_sel;
  logic [DATA_W-1:0]  cur_val;
  logic [FRAME_W-1:0] cur_word;

  assign tx_go      = (st == S_LOAD);
  assign last_frame = (idx_q + 1'b1 == cnt_q);
  assign ls_go      = (st == S_WAIT) && tx_fin && last_frame && lat_q;
  assign chip_sel   = idx_q >> 1;
  assign cur_val    = samples[int'(idx_q) * DATA_W +: DATA_W];
  assign cur_word   = build_word(idx_q[0], cur_val);
  assign busy       = (st != S_IDLE);
  assign done       = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      lat_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          cnt_q <= CNT_W'(clamp_count(int'(chan_count), N_CH));
          idx_q <= '0;
          lat_q <= latch_req;
          st    <= S_LOAD;
        end
        S_LOAD: st <= S_WAIT;
        S_WAIT: if (tx_fin) begin
          if (!last_frame) begin
            idx_q <= idx_q + 1'b1;
            st    <= S_LOAD;
          end else st <= lat_q ? S_LATCH : S_DONE;
        end
        S_LATCH: if (ls_fin) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar k = 0; k < N_CHIPS; k++) begin : g_cs
    assign cs_n[k] = !(tx_active && (chip_sel == CNT_W'(k)));
  end

  dac_spi_frame #(.FRAME_W(FRAME_W), .HALF_DIV(HALF_DIV)) u_frame (
    .clk(clk), .rst_n(rst_n), .go(tx_go), .word(cur_word),
    .active(tx_active), .fin(tx_fin), .sclk(sclk), .mosi(mosi));

  dac_load_strobe #(.SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC)) u_strobe (
    .clk(clk), .rst_n(rst_n), .go(ls_go), .ldac_n(ldac_n), .fin(ls_fin));

  // R4
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  // R7
  strobe_no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ldac_n |-> (&cs_n));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ((&cs_n) && ldac_n && !sclk));
  // R8
  no_latch_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !lat_q) |-> ldac_n);
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/tb_dac_seq_top.sv
module tb_dac_seq_top;
  localparam int N_CHIPS = 2;
  localparam int N_CH    = 2 * N_CHIPS;
  localparam int CNT_W   = $clog2(2 * N_CHIPS + 1) + 1;
  localparam int SETUP_C = 4;   // ceil(40/10)
  localparam int PULSE_C = 10;  // ceil(100/10)

  logic clk = 0, rst_n = 0, start = 0, latch_req = 0;
  logic [CNT_W-1:0] chan_count = '0;
  logic [N_CH*12-1:0] samples = '0;
  logic busy, done, sclk, mosi, ldac_n;
  logic [N_CHIPS-1:0] cs_n;

  int n_chk = 0, n_bad = 0;

  dac_seq_top dut (.clk(clk), .rst_n(rst_n), .start(start), .latch_req(latch_req),
    .chan_count(chan_count), .samples(samples), .busy(busy), .done(done),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .ldac_n(ldac_n));

  always #5 clk = ~clk;

  // Monitor state (sampled on falling clock edge)
  logic [15:0] cap_word [0:15];
  int          cap_chip [0:15];
  int          cap_bits [0:15];
  int          ncap = 0;
  logic [15:0] sh = '0;
  int          bits = 0, cur_chip = -1;
  logic        p_sclk = 0, p_ldac = 1, p_any = 0;
  int          gap = 0, last_gap = -1, low_len = 0, falls = 0, max_low = 0;
  int          mode_err = 0, overlap_err = 0, multi_err = 0;

  always @(negedge clk) begin
    logic any;
    int nlow;
    nlow = 0;
    for (int k = 0; k < N_CHIPS; k++) if (!cs_n[k]) begin nlow++; cur_chip = k; end
    any = (nlow != 0);
    if (nlow > 1) multi_err++;
    if (any && !ldac_n) overlap_err++;
    if (sclk && p_sclk && (mosi !== sh[0]) && 0) mode_err++;
    gap++;
    if (sclk && !p_sclk && any) begin sh = {sh[14:0], mosi}; bits++; end
    if (p_any && !any) begin
      if (ncap < 16) begin
        cap_word[ncap] = sh; cap_chip[ncap] = cur_chip; cap_bits[ncap] = bits;
      end
      ncap++; bits = 0; gap = 0;
    end
    if (p_ldac && !ldac_n) begin falls++; last_gap = gap; low_len = 0; end
    if (!ldac_n) begin low_len++; if (low_len > max_low) max_low = low_len; end
    if (sclk === 1'bx || (!any && sclk)) mode_err++;
    p_sclk = sclk; p_ldac = ldac_n; p_any = any;
  end

  function automatic int exp_count(int req);
    return (req < 1) ? 1 : (req > N_CH ? N_CH : req);
  endfunction
  function automatic logic [15:0] exp_word(int i, logic [11:0] v);
    logic [3:0] nib;
    nib = (i % 2 == 1) ? 4'hB : 4'h3;
    return {nib, v};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    ncap = 0; falls = 0; last_gap = -1; max_low = 0;
    mode_err = 0; overlap_err = 0; multi_err = 0;
  endtask

  task automatic run_batch(int req, bit lat, bit poke);
    int t, ec;
    bit seen_busy;
    clear_mon();
    @(negedge clk);
    chan_count = CNT_W'(req); latch_req = lat; start = 1;
    @(negedge clk);
    start = 0;
    seen_busy = busy;
    t = 0;
    while (!done && t < 5000) begin
      @(negedge clk); t++;
      if (poke && t == 20) begin start = 1; latch_req = !lat; chan_count = CNT_W'(1); end
      if (poke && t == 21) start = 0;
    end
    check(t < 5000, "R9 watchdog", t, 0);
    check(seen_busy, "R9 busy", seen_busy, 1);
    @(negedge clk);
    check(!done, "R9 done pulse", done, 0);
    repeat (60) @(negedge clk);
    ec = exp_count(req);
    check(ncap == ec, "R5 count", ncap, ec);
    for (int i = 0; i < ec && i < ncap; i++) begin
      logic [15:0] w;
      w = exp_word(i, samples[i*12 +: 12]);
      check(cap_word[i] == w, "R3 word", cap_word[i], w);
      check(cap_chip[i] == i / 2, "R6 chip", cap_chip[i], i / 2);
      check(cap_bits[i] == 16, "R2 bits", cap_bits[i], 16);
    end
    check(multi_err == 0 && overlap_err == 0, "R4 selects", multi_err + overlap_err, 0);
    check(mode_err == 0, "R2 mode", mode_err, 0);
    if (lat) begin
      check(falls == 1, "R7 strobe", falls, 1);
      check(last_gap >= SETUP_C, "R7 setup", last_gap, SETUP_C);
      check(max_low == PULSE_C, "R7 width R10", max_low, PULSE_C);
      check(ldac_n, "R7 release", ldac_n, 1);
    end else begin
      check(falls == 0, "R8 no strobe", falls, 0);
    end
    check(!busy && (&cs_n), "R1 idle", {busy, cs_n}, 3);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED1);
    repeat (3) @(negedge clk);
    check(&cs_n, "R1 cs reset", cs_n, 3);
    check(ldac_n && !sclk && !busy, "R1 idle reset", {ldac_n, sclk, busy}, 4);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // directed corners
    samples = {12'hFFF, 12'h000, 12'hABC, 12'h123};
    run_batch(0, 0, 0);      // R5 zero clamps to one
    run_batch(7, 1, 0);      // R5 over clamps to max, R7
    run_batch(3, 1, 0);      // R6 odd count ends on A
    run_batch(2, 0, 1);      // R9 start while busy ignored
    run_batch(4, 1, 1);      // R9 latch change while busy ignored
    for (int n = 0; n < 20; n++) begin
      for (int k = 0; k < N_CH; k++) samples[k*12 +: 12] = 12'($urandom);
      run_batch(int'($urandom % 8), 1'($urandom), 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(1_500_000ns);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule